// File: doc/BRIEF.md
# Indirect Interrupt Register Window

This block is the software-facing register front end of a 24-pin I/O interrupt router. Software reaches every register through two bus offsets: a select register at offset 0x00 and a data window at offset 0x10. The value held in the select register picks what the window shows. It can show a read-only version word, a writable 4-bit router identifier, a read-only arbitration word, or one 32-bit half of a 64-bit redirection entry. There is one redirection entry per input pin.

The block stores the redirection table and the identifier. It reports edits to the delivery engine next to it, and it never decides on its own when an interrupt is delivered. The delivery engine supplies the per-pin pending bits. It also raises a per-pin strobe that sets an entry's remote-acknowledge flag when it delivers a level-triggered interrupt. After every entry write, the block pulses an update strobe for the affected pin. It issues a service request when the written entry is level-triggered and its pin is pending. It emits a mask-change pulse when the write flips the entry's mask bit.

Top module: `irq_window`

## Requirements
- R1: With select = 0x01, a window read returns (pin count − 1) in bits 23:16 and the 8-bit version code (default 0x11) in bits 7:0, all other bits zero. With 24 pins this is 0x00170011.
- R2: Selects 0x00 and 0x02 both read the 4-bit identifier in bits 27:24, with other bits zero. A window write with select 0x00 loads the identifier from data bits 27:24. Window writes with select 0x01 or 0x02 change no register.
- R3: For select ≥ 0x10, the entry number is (select − 0x10) >> 1. An odd select reads and writes entry bits 63:32, and an even select reads and writes bits 31:0.
- R4: A window read whose entry number is at or beyond the pin count returns 0xFFFFFFFF. This also applies to selects 0x03–0x0F. A window write to such an entry changes nothing and raises no pulse.
- R5: Entry bit 14 is the remote-acknowledge flag. A pulse on the pin's remote-set input sets it. A low-half write always leaves it cleared, whatever data bit 14 holds, and the write wins over a simultaneous set.
- R6: A write at offset 0x00 keeps only data bits 7:0 as the select. A read at offset 0x00 returns the select, zero-extended.
- R7: After reset, the select and the identifier are zero, and every entry reads low half 0x00010000 (mask bit 16 set) and high half 0.
- R8: In the cycle after any entry write, the update strobe is high with the pin index. The service-request strobe is high with the pin index only if the entry after the write has bit 15 = 1 (level) and that pin's pending input is high.
- R9: In the cycle after an entry write that changes mask bit 16, the mask-change strobe is high with the pin index and the new mask value. If the mask bit is unchanged, no mask-change strobe is raised.
- R10: Reads at offsets other than 0x00 and 0x10 return zero, and writes there change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Bus offset |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| pend_i | input | 24 | Per-pin pending bits from the delivery engine |
| remote_set_i | input | 24 | Per-pin strobe that sets remote-acknowledge |
| upd_o | output | 1 | Entry-written pulse |
| upd_pin_o | output | 5 | Pin of the written entry |
| svc_req_o | output | 1 | Service-request pulse |
| svc_pin_o | output | 5 | Pin to service |
| mask_chg_o | output | 1 | Mask-change pulse |
| mask_pin_o | output | 5 | Pin whose mask changed |
| mask_val_o | output | 1 | New mask value |

## Verification
Several properties are checked on every cycle. The select and the identifier stay stable unless their own write occurs, and a low-half write always leaves remote-acknowledge clear. At most one entry is written per cycle, and the service and mask strobes only follow a window write. The bench scenarios show what a stable-or-pulse rule cannot. These include the exact read words for each index, the all-ones answer for missing entries, the masking of data bit 14, and the level/pending/mask conditions that decide which strobes appear.

// File: rtl/irqw_pkg.sv
package irqw_pkg;
  localparam logic [7:0] OFF_SEL  = 8'h00;
  localparam logic [7:0] OFF_WIN  = 8'h10;
  localparam logic [7:0] IX_ID    = 8'h00;
  localparam logic [7:0] IX_VER   = 8'h01;
  localparam logic [7:0] IX_ARB   = 8'h02;
  localparam logic [7:0] IX_ENT   = 8'h10;
  localparam int         B_REMOTE = 14;
  localparam int         B_LEVEL  = 15;
  localparam int         B_MASK   = 16;
  localparam logic [63:0] ENT_RST = 64'h0000_0000_0001_0000;

  typedef enum logic [2:0] {
    K_ID, K_VER, K_ARB, K_ENT, K_BAD
  } kind_e;
endpackage

// File: rtl/irqw_decode.sv
module irqw_decode #(
  parameter int NPINS = 24,
  localparam int IDX_W = $clog2(NPINS)
) (
  input  logic [7:0]           sel_i,
  output irqw_pkg::kind_e      kind_o,
  output logic [IDX_W-1:0]     idx_o,
  output logic                 hi_o
);
  import irqw_pkg::*;
  logic [7:0] off;
  logic [6:0] num;

  always_comb begin
    off    = sel_i - IX_ENT;
    num    = off[7:1];
    hi_o   = sel_i[0];
    idx_o  = num[IDX_W-1:0];
    kind_o = K_BAD;
    if (sel_i == IX_ID)                              kind_o = K_ID;
    else if (sel_i == IX_VER)                        kind_o = K_VER;
    else if (sel_i == IX_ARB)                        kind_o = K_ARB;
    else if (sel_i >= IX_ENT && 32'(num) < NPINS)    kind_o = K_ENT;
  end
endmodule

// File: rtl/irqw_entry.sv
module irqw_entry (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_lo_i,
  input  logic        wr_hi_i,
  input  logic [31:0] wdata_i,
  input  logic        remote_set_i,
  output logic [63:0] ent_o
);
  import irqw_pkg::*;
  logic [63:0] ent_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ent_q <= ENT_RST;
    else begin
      if (remote_set_i) ent_q[B_REMOTE] <= 1'b1;
      if (wr_hi_i) ent_q[63:32] <= wdata_i;
      if (wr_lo_i) begin
        ent_q[31:0]     <= wdata_i;
        ent_q[B_REMOTE] <= 1'b0;  // low write always drops the flag
      end
    end
  end

  assign ent_o = ent_q;

  AST_LO_CLEARS_REMOTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_i |=> !ent_o[B_REMOTE]); // R5
endmodule

// File: rtl/irq_window.sv
module irq_window #(
  parameter int          NPINS   = 24,
  parameter logic [7:0]  VERSION = 8'h11,
  localparam int         IDX_W   = $clog2(NPINS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        addr_i,
  input  logic              wr_en_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [NPINS-1:0]  pend_i,
  input  logic [NPINS-1:0]  remote_set_i,
  output logic              upd_o,
  output logic [IDX_W-1:0]  upd_pin_o,
  output logic              svc_req_o,
  output logic [IDX_W-1:0]  svc_pin_o,
  output logic              mask_chg_o,
  output logic [IDX_W-1:0]  mask_pin_o,
  output logic              mask_val_o
);
  import irqw_pkg::*;

  logic [7:0]       sel_q;
  logic [3:0]       id_q;
  kind_e            kind;
  logic [IDX_W-1:0] idx;
  logic             hi;
  logic             win_wr, sel_wr, ent_wr;
  logic [NPINS-1:0] wr_lo, wr_hi;
  logic [63:0]      ents [NPINS];
  logic [63:0]      cur;
  logic [31:0]      win_rd;
  logic             new_level, new_mask;

  irqw_decode #(.NPINS(NPINS)) u_dec (
    .sel_i (sel_q),
    .kind_o(kind),
    .idx_o (idx),
    .hi_o  (hi)
  );

  assign sel_wr = wr_en_i && addr_i == OFF_SEL;
  assign win_wr = wr_en_i && addr_i == OFF_WIN;
  assign ent_wr = win_wr && kind == K_ENT;

  for (genvar p = 0; p < NPINS; p++) begin : g_ent
    assign wr_lo[p] = ent_wr && !hi && idx == IDX_W'(p);
    assign wr_hi[p] = ent_wr &&  hi && idx == IDX_W'(p);
    irqw_entry u_ent (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_lo_i     (wr_lo[p]),
      .wr_hi_i     (wr_hi[p]),
      .wdata_i     (wdata_i),
      .remote_set_i(remote_set_i[p]),
      .ent_o       (ents[p])
    );
  end

  assign cur = (kind == K_ENT) ? ents[idx] : '1;

  always_comb begin
    unique case (kind)
      K_VER:       win_rd = {8'h00, 8'(NPINS - 1), 8'h00, VERSION};
      K_ID, K_ARB: win_rd = {4'h0, id_q, 24'h0};
      K_ENT:       win_rd = hi ? cur[63:32] : cur[31:0];
      default:     win_rd = '1;
    endcase
    case (addr_i)
      OFF_SEL: rdata_o = {24'h0, sel_q};
      OFF_WIN: rdata_o = win_rd;
      default: rdata_o = '0;
    endcase
  end

  // level and mask live in the low half; a high write keeps them
  assign new_level = hi ? cur[B_LEVEL] : wdata_i[B_LEVEL];
  assign new_mask  = hi ? cur[B_MASK]  : wdata_i[B_MASK];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q      <= '0;
      id_q       <= '0;
      upd_o      <= 1'b0;
      upd_pin_o  <= '0;
      svc_req_o  <= 1'b0;
      svc_pin_o  <= '0;
      mask_chg_o <= 1'b0;
      mask_pin_o <= '0;
      mask_val_o <= 1'b0;
    end else begin
      if (sel_wr) sel_q <= wdata_i[7:0];
      if (win_wr && kind == K_ID) id_q <= wdata_i[27:24];
      upd_o      <= ent_wr;
      svc_req_o  <= ent_wr && new_level && pend_i[idx];
      mask_chg_o <= ent_wr && new_mask != cur[B_MASK];
      if (ent_wr) begin
        upd_pin_o  <= idx;
        svc_pin_o  <= idx;
        mask_pin_o <= idx;
        mask_val_o <= new_mask;
      end
    end
  end

  AST_ID_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(win_wr && sel_q == IX_ID) |=> $stable(id_q)); // R2
  AST_SEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == OFF_SEL) |=> $stable(sel_q)); // R6
  AST_ONE_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_lo, wr_hi})); // R3
  AST_SVC_AFTER_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_req_o |-> $past(wr_en_i && addr_i == OFF_WIN)); // R8
  AST_SVC_HAS_UPD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_req_o |-> upd_o && svc_pin_o == upd_pin_o); // R8
  AST_MASK_AFTER_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_chg_o |-> $past(wr_en_i && addr_i == OFF_WIN)); // R9
endmodule

// File: tb/irq_window_tb.sv
module irq_window_tb;
  localparam int NPINS = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NPINS-1:0] pend = '0, rset = '0;
  logic        upd, svc, mchg, mval;
  logic [4:0]  upd_pin, svc_pin, mpin;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  irq_window u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .wdata_i(wdata), .rdata_o(rdata), .pend_i(pend), .remote_set_i(rset),
    .upd_o(upd), .upd_pin_o(upd_pin), .svc_req_o(svc), .svc_pin_o(svc_pin),
    .mask_chg_o(mchg), .mask_pin_o(mpin), .mask_val_o(mval)
  );

  typedef struct packed {
    logic        wr;
    logic [7:0]  a;
    logic [31:0] d;   // write data, or expected read data
    logic [3:0]  req;
  } step_t;

  localparam int NSTEP = 24;
  localparam step_t TBL [NSTEP] = '{
    '{1'b1, 8'h00, 32'h0000_0001, 4'd1},
    '{1'b0, 8'h10, 32'h0017_0011, 4'd1},  // R1 version
    '{1'b1, 8'h10, 32'hFFFF_FFFF, 4'd2},
    '{1'b0, 8'h10, 32'h0017_0011, 4'd2},  // R2 version write ignored
    '{1'b1, 8'h00, 32'h0000_0000, 4'd2},
    '{1'b1, 8'h10, 32'hA5FF_FFFF, 4'd2},
    '{1'b0, 8'h10, 32'h0500_0000, 4'd2},  // R2 id takes 27:24
    '{1'b1, 8'h00, 32'h0000_0002, 4'd2},
    '{1'b0, 8'h10, 32'h0500_0000, 4'd2},  // R2 arb shows id
    '{1'b1, 8'h10, 32'hFF00_0000, 4'd2},
    '{1'b0, 8'h10, 32'h0500_0000, 4'd2},  // R2 arb write ignored
    '{1'b1, 8'h00, 32'h0000_001E, 4'd3},
    '{1'b1, 8'h10, 32'h0001_C030, 4'd5},
    '{1'b0, 8'h10, 32'h0001_8030, 4'd5},  // R5 bit 14 dropped, R3 low half
    '{1'b1, 8'h00, 32'h0000_001F, 4'd3},
    '{1'b1, 8'h10, 32'hC100_0000, 4'd3},
    '{1'b0, 8'h10, 32'hC100_0000, 4'd3},  // R3 high half
    '{1'b1, 8'h00, 32'h0000_0040, 4'd4},
    '{1'b0, 8'h10, 32'hFFFF_FFFF, 4'd4},  // R4 entry 24
    '{1'b1, 8'h00, 32'h1234_5633, 4'd6},
    '{1'b0, 8'h00, 32'h0000_0033, 4'd6},  // R6 low byte kept
    '{1'b0, 8'h20, 32'h0000_0000, 4'd10}, // R10 other offset
    '{1'b1, 8'h20, 32'h0000_00AA, 4'd10},
    '{1'b0, 8'h00, 32'h0000_0033, 4'd10}  // R10 write ignored
  };

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R7 reset state
    rd(8'h00, v); chk("R7 select", v, 32'h0);
    rd(8'h10, v); chk("R7 id", v, 32'h0);
    wr(8'h00, 32'h10); rd(8'h10, v); chk("R7 entry0 lo", v, 32'h0001_0000);
    wr(8'h00, 32'h3F); rd(8'h10, v); chk("R7 entry23 hi", v, 32'h0);

    for (int i = 0; i < NSTEP; i++) begin
      if (TBL[i].wr) wr(TBL[i].a, TBL[i].d);
      else begin
        rd(TBL[i].a, v);
        chk($sformatf("R%0d step %0d", TBL[i].req, i), v, TBL[i].d);
      end
    end

    // R4 select below entry range, and dropped write
    wr(8'h00, 32'h05); rd(8'h10, v); chk("R4 sel 0x05", v, 32'hFFFF_FFFF);
    wr(8'h00, 32'h41); wr(8'h10, 32'h0);
    chk("R4 no pulse", {29'h0, upd, svc, mchg}, 32'h0);

    // R5 remote set, then low write clears
    @(negedge clk); rset[4] = 1'b1; @(negedge clk); rset[4] = 1'b0;
    wr(8'h00, 32'h18); rd(8'h10, v); chk("R5 remote set", v, 32'h0001_4000);
    wr(8'h10, 32'h0000_0020);
    chk("R9 mask pulse", {mchg, mval, 3'b0, mpin}, {2'b10, 3'b0, 5'd4});
    rd(8'h10, v); chk("R5 remote cleared", v, 32'h0000_0020);

    // R8 level + pending -> service
    pend[5] = 1'b1; pend[6] = 1'b1;
    wr(8'h00, 32'h1A); wr(8'h10, 32'h0000_8041);
    chk("R8 svc level", {svc, 3'b0, svc_pin}, {1'b1, 3'b0, 5'd5});
    chk("R8 upd", {upd, 3'b0, upd_pin}, {1'b1, 3'b0, 5'd5});
    wr(8'h10, 32'h0000_8041);
    chk("R9 mask unchanged", {31'h0, mchg}, 32'h0);
    wr(8'h00, 32'h1B); wr(8'h10, 32'h0F00_0000);
    chk("R8 svc on high write", {svc, 3'b0, svc_pin}, {1'b1, 3'b0, 5'd5});
    wr(8'h00, 32'h1C); wr(8'h10, 32'h0000_0042);
    chk("R8 edge no svc", {upd, svc}, 32'h2);
    pend[6] = 1'b0;
    wr(8'h00, 32'h1D); wr(8'h10, 32'h0);
    wr(8'h00, 32'h1C); wr(8'h10, 32'h0001_8042);
    chk("R8 level not pending", {upd, svc}, 32'h2);
    chk("R9 mask set", {mchg, mval, 3'b0, mpin}, {2'b11, 3'b0, 5'd6});

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule